// File: doc/BRIEF.md
# Differential Burst Framer

This block builds one transmit burst and shifts it out one bit at a time. A burst is 27 bytes long. It starts with a fixed 13-byte header: a preamble run followed by a sync word. After the header come 14 payload bytes that are already coded. An upstream source supplies the payload bytes over a valid/ready byte port. Every bit, header bits included, passes through an inverted transition encoder before it reaches the serial output. The encoder keeps its memory of the previous raw bit across byte and field boundaries.

A start strobe launches the burst. After that, the output advances by one bit on each clock edge where the pacing strobe is high. The caller can therefore space the bits at any baud rate derived from the clock. A busy level and a one-cycle done pulse frame the transfer. If a payload byte has not arrived by the time its first bit is needed, the block raises an underrun pulse and sends a zero byte in that position.

Top module: `burst_framer`

## Requirements
- R1: The first 64 bits of a burst are the raw bytes 0x55, 0x55, 0x55, 0x00, 0x00, 0x00, 0x00, 0x0A, in that order, before encoding.
- R2: Raw bits 64 to 103 are the sync bytes 0x07, 0x09, 0x2A, 0x44, 0x6F, in that order, before encoding.
- R3: Raw bits 104 to 215 are the 14 payload bytes, sent in the order they were accepted on the byte port. A burst is 216 bits in total.
- R4: Each byte is sent most significant bit first. `tx_bit_o` takes its next value only on an edge where `busy_o` and `bit_en_i` are both high. Otherwise it holds its value.
- R5: The encoded output is 1 when the raw bit equals the previous raw bit, and 0 when it differs. The previous raw bit is 0 at burst start and is carried across all byte boundaries.
- R6: `done_o` is high for exactly one cycle. That cycle is the one in which the 216th encoded bit is on `tx_bit_o`. `busy_o` falls on the same edge.
- R7: While idle (`busy_o` and `done_o` both low), `tx_bit_o` and `byte_ready_o` are 0.
- R8: A high `start_i` while `busy_o` is high is ignored. The bit stream and the burst length are unchanged.
- R9: If the payload buffer is empty when the first bit of a payload byte is sent, that byte goes out as 0x00 and `underrun_o` pulses for one cycle. The slot counts as used, so one fewer byte is accepted in that burst.
- R10: `byte_ready_o` is high only while busy, with the single-byte buffer empty and payload slots still open. At most 14 bytes are accepted per burst.
- R11: A low `rst_n` sampled at a clock edge returns the block to idle with all outputs 0, including in the middle of a burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| start_i | input | 1 | Launches a burst when idle |
| bit_en_i | input | 1 | Pacing strobe; one output bit per high cycle while busy |
| byte_data_i | input | 8 | Payload byte |
| byte_valid_i | input | 1 | Payload byte is valid |
| byte_ready_o | output | 1 | Block can take a payload byte |
| tx_bit_o | output | 1 | Encoded serial bit |
| busy_o | output | 1 | Burst in progress |
| done_o | output | 1 | One-cycle pulse with the final bit |
| underrun_o | output | 1 | One-cycle pulse when a payload byte arrived too late |

## Verification
The encoder carries state across bits, so one wrong bit does not stay local. A bad header constant, a wrong bit order or a mishandled previous-bit register corrupts the encoded stream at the first affected bit. Because the next bit is encoded against it, the error spreads to the neighbouring bit as well, and the per-bit scoreboard reports it on the same edge. A fault in the bit counter shows up as a done pulse at the wrong bit count. A fault in the payload staging shows up as payload bits that do not match, or as a changed count of accepted bytes or underrun pulses by the end of that burst.

// File: rtl/framer_pkg.sv
// Package: shared constants for the burst framer.
// Holds the fixed header pattern (preamble followed by sync word).
// Assumes byte indices below HDR_BYTES address the header.
package framer_pkg;

    localparam int unsigned PRE_BYTES  = 8;
    localparam int unsigned SYNC_BYTES = 5;
    localparam int unsigned HDR_BYTES  = PRE_BYTES + SYNC_BYTES;

    // Returns the raw header byte at a given byte index of the burst.
    function automatic logic [7:0] hdr_byte(input int unsigned idx);
        logic [7:0] v;
        case (idx)
            0, 1, 2:       v = 8'h55;
            3, 4, 5, 6:    v = 8'h00;
            7:             v = 8'h0A;
            8:             v = 8'h07;
            9:             v = 8'h09;
            10:            v = 8'h2A;
            11:            v = 8'h44;
            12:            v = 8'h6F;
            default:       v = 8'h00;
        endcase
        return v;
    endfunction

endpackage

// File: rtl/framer_sequencer.sv
// Module: framer_sequencer
// Tracks the burst: busy level, bit position and the done pulse.
// Assumes start is only honoured while idle; a step advances one bit.
module framer_sequencer #(
    parameter int unsigned TOTAL_BITS = 216,
    localparam int unsigned CNT_W     = $clog2(TOTAL_BITS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             bit_en_i,
    output logic             go_o,
    output logic             step_o,
    output logic [CNT_W-1:0] bit_cnt_o,
    output logic             busy_o,
    output logic             done_o
);

    logic             busy_q;
    logic             done_q;
    logic [CNT_W-1:0] cnt_q;

    assign go_o   = start_i & ~busy_q;
    assign step_o = busy_q & bit_en_i;

    // Advance the bit counter and raise done with the final bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            done_q <= 1'b0;
            cnt_q  <= '0;
        end else begin
            done_q <= 1'b0;
            if (go_o) begin
                busy_q <= 1'b1;
                cnt_q  <= '0;
            end else if (step_o) begin
                if (cnt_q == CNT_W'(TOTAL_BITS - 1)) begin
                    busy_q <= 1'b0;
                    done_q <= 1'b1;
                    cnt_q  <= '0;
                end else begin
                    cnt_q <= cnt_q + 1'b1;
                end
            end
        end
    end

    assign bit_cnt_o = cnt_q;
    assign busy_o    = busy_q;
    assign done_o    = done_q;

endmodule

// File: rtl/framer_stager.sv
// Module: framer_stager
// Single-byte payload buffer with a per-burst slot budget.
// A claim takes the buffered byte for the next payload slot; if the
// buffer is empty the slot is sent as zero and an underrun is flagged.
module framer_stager #(
    parameter int unsigned PAYLOAD_BYTES = 14,
    localparam int unsigned REM_W        = $clog2(PAYLOAD_BYTES + 1)
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       go_i,
    input  logic       busy_i,
    input  logic       claim_i,
    input  logic [7:0] data_i,
    input  logic       valid_i,
    output logic       ready_o,
    output logic [7:0] slot_byte_o,
    output logic [7:0] held_o,
    output logic       underrun_o
);

    logic [7:0]       buf_q;
    logic             full_q;
    logic [REM_W-1:0] rem_q;
    logic [7:0]       held_q;
    logic             under_q;
    logic             take;
    logic             miss;

    assign ready_o     = busy_i & ~full_q & (rem_q != '0);
    assign take        = ready_o & valid_i;
    assign miss        = claim_i & ~full_q;
    assign slot_byte_o = full_q ? buf_q : 8'h00;

    // Hold the buffer, the slot budget and the byte being serialised.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            buf_q   <= '0;
            full_q  <= 1'b0;
            rem_q   <= '0;
            held_q  <= '0;
            under_q <= 1'b0;
        end else begin
            under_q <= miss;
            if (go_i) begin
                full_q <= 1'b0;
                rem_q  <= REM_W'(PAYLOAD_BYTES);
            end else begin
                rem_q <= rem_q - REM_W'(take) - REM_W'(miss);
                if (take) begin
                    buf_q  <= data_i;
                    full_q <= 1'b1;
                end else if (claim_i) begin
                    full_q <= 1'b0;
                end
                if (claim_i) begin
                    held_q <= slot_byte_o;
                end
            end
        end
    end

    assign held_o     = held_q;
    assign underrun_o = under_q;

endmodule

// File: rtl/diff_encoder.sv
// Module: diff_encoder
// Inverted transition encoder: emits 1 when the raw bit repeats,
// 0 when it changes. Previous-bit memory persists across bytes.
module diff_encoder (
    input  logic clk,
    input  logic rst_n,
    input  logic clear_i,
    input  logic step_i,
    input  logic raw_i,
    output logic enc_o
);

    logic prev_q;
    logic enc_q;

    // Update the encoded bit and remember the raw bit on each step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_q <= 1'b0;
            enc_q  <= 1'b0;
        end else if (clear_i) begin
            prev_q <= 1'b0;
            enc_q  <= 1'b0;
        end else if (step_i) begin
            enc_q  <= ~(raw_i ^ prev_q);
            prev_q <= raw_i;
        end
    end

    assign enc_o = enc_q;

endmodule

// File: rtl/burst_framer.sv
// Module: burst_framer (top)
// Serialises header then payload MSB first through the differential
// encoder, one bit per paced step. Assumes the caller paces bit_en_i.
module burst_framer #(
    parameter int unsigned PAYLOAD_BYTES = 14,
    localparam int unsigned TOTAL_BYTES  = framer_pkg::HDR_BYTES + PAYLOAD_BYTES,
    localparam int unsigned TOTAL_BITS   = TOTAL_BYTES * 8,
    localparam int unsigned CNT_W        = $clog2(TOTAL_BITS)
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start_i,
    input  logic       bit_en_i,
    input  logic [7:0] byte_data_i,
    input  logic       byte_valid_i,
    output logic       byte_ready_o,
    output logic       tx_bit_o,
    output logic       busy_o,
    output logic       done_o,
    output logic       underrun_o
);

    logic             go;
    logic             step;
    logic [CNT_W-1:0] bit_cnt;
    logic             busy;
    logic             done;
    logic [CNT_W-4:0] byte_idx;
    logic [2:0]       bit_pos;
    logic             in_payload;
    logic             claim;
    logic [7:0]       hdr_val;
    logic [7:0]       slot_byte;
    logic [7:0]       held;
    logic             raw;
    logic             enc;

    framer_sequencer #(.TOTAL_BITS(TOTAL_BITS)) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .start_i  (start_i),
        .bit_en_i (bit_en_i),
        .go_o     (go),
        .step_o   (step),
        .bit_cnt_o(bit_cnt),
        .busy_o   (busy),
        .done_o   (done)
    );

    assign byte_idx   = bit_cnt[CNT_W-1:3];
    assign bit_pos    = bit_cnt[2:0];
    assign in_payload = int'(byte_idx) >= int'(framer_pkg::HDR_BYTES);
    assign claim      = step & in_payload & (bit_pos == 3'd0);
    assign hdr_val    = framer_pkg::hdr_byte(int'(byte_idx));

    framer_stager #(.PAYLOAD_BYTES(PAYLOAD_BYTES)) u_stage (
        .clk        (clk),
        .rst_n      (rst_n),
        .go_i       (go),
        .busy_i     (busy),
        .claim_i    (claim),
        .data_i     (byte_data_i),
        .valid_i    (byte_valid_i),
        .ready_o    (byte_ready_o),
        .slot_byte_o(slot_byte),
        .held_o     (held),
        .underrun_o (underrun_o)
    );

    // Pick the raw bit for the current position, MSB first.
    always_comb begin
        if (!in_payload) begin
            raw = hdr_val[3'd7 - bit_pos];
        end else if (bit_pos == 3'd0) begin
            raw = slot_byte[7];
        end else begin
            raw = held[3'd7 - bit_pos];
        end
    end

    diff_encoder u_enc (
        .clk    (clk),
        .rst_n  (rst_n),
        .clear_i(go),
        .step_i (step),
        .raw_i  (raw),
        .enc_o  (enc)
    );

    assign tx_bit_o = enc & (busy | done);
    assign busy_o   = busy;
    assign done_o   = done;

endmodule

// File: rtl/framer_checker.sv
// Module: framer_checker
// Port-level temporal properties for burst_framer, bound to the top.
module framer_checker (
    input logic clk,
    input logic rst_n,
    input logic start_i,
    input logic bit_en_i,
    input logic byte_ready_o,
    input logic tx_bit_o,
    input logic busy_o,
    input logic done_o,
    input logic underrun_o
);

    // R6: done arrives only as busy ends.
    p_done_ends_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (!busy_o && $past(busy_o)));

    // R6: done never lasts two cycles.
    p_done_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R7: quiet outputs while idle.
    p_idle_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && !done_o) |-> (!tx_bit_o && !byte_ready_o));

    // R10: ready only inside a burst.
    p_ready_in_burst_r10: assert property (@(posedge clk) disable iff (!rst_n)
        byte_ready_o |-> busy_o);

    // R8: a start during a burst does not end or restart it early.
    p_start_ignored_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && start_i && !bit_en_i) |=> busy_o);

    // R4: no pacing strobe, no change on the line.
    p_hold_without_en_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && !bit_en_i) |=> (busy_o && $stable(tx_bit_o)));

    // R9: underrun only flagged during a burst.
    p_underrun_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
        underrun_o |-> busy_o);

endmodule

bind burst_framer framer_checker u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start_i),
    .bit_en_i    (bit_en_i),
    .byte_ready_o(byte_ready_o),
    .tx_bit_o    (tx_bit_o),
    .busy_o      (busy_o),
    .done_o      (done_o),
    .underrun_o  (underrun_o)
);

// File: tb/tb_burst_framer.sv
module tb_burst_framer;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start_i = 1'b0;
    logic       bit_en_i;
    logic [7:0] byte_data_i;
    logic       byte_valid_i;
    logic       byte_ready_o, tx_bit_o, busy_o, done_o, underrun_o;

    int vectors = 0;
    int fails = 0;

    always #10 clk = ~clk;   // 50 MHz

    burst_framer dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .bit_en_i(bit_en_i),
        .byte_data_i(byte_data_i), .byte_valid_i(byte_valid_i),
        .byte_ready_o(byte_ready_o), .tx_bit_o(tx_bit_o), .busy_o(busy_o),
        .done_o(done_o), .underrun_o(underrun_o)
    );

    // Pacing: 0 = off, 1 = every cycle, 2 = one cycle in three
    int         pace = 0;
    logic [1:0] div = 0;
    always @(posedge clk) div <= (div == 2) ? 2'd0 : div + 1'b1;
    assign bit_en_i = (pace == 1) || (pace == 2 && div == 0);

    // Payload feeder
    logic [7:0] pay [14];
    int         feed_idx = 0;
    logic       feed_en = 1'b0;
    logic       feed_clr = 1'b0;
    assign byte_valid_i = feed_en && feed_idx < 14;
    assign byte_data_i  = pay[feed_idx < 14 ? feed_idx : 0];
    always @(posedge clk) begin
        if (feed_clr) feed_idx <= 0;
        else if (byte_valid_i && byte_ready_o) feed_idx <= feed_idx + 1;
    end

    // Scoreboard
    logic exp_q[$];
    logic emit_q = 1'b0;
    int   emitted = 0;
    int   under_cnt = 0;
    int   done_cnt = 0;
    int   done_at = -1;

    task automatic check(input bit ok, input string req, input int act, input int expv);
        vectors++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    // Driver side: build expected encoded stream from R1/R2/R3/R5
    task automatic push_burst(input bit zero_payload);
        logic [7:0] b [27];
        logic prev = 1'b0;
        b[0] = 8'h55; b[1] = 8'h55; b[2] = 8'h55; b[3] = 8'h00;
        b[4] = 8'h00; b[5] = 8'h00; b[6] = 8'h00; b[7] = 8'h0A;
        b[8] = 8'h07; b[9] = 8'h09; b[10] = 8'h2A; b[11] = 8'h44; b[12] = 8'h6F;
        for (int i = 0; i < 14; i++) b[13+i] = zero_payload ? 8'h00 : pay[i];
        for (int i = 0; i < 27; i++)
            for (int k = 7; k >= 0; k--) begin
                exp_q.push_back(~(b[i][k] ^ prev));
                prev = b[i][k];
            end
    endtask

    always @(posedge clk) emit_q <= bit_en_i && busy_o && rst_n;

    // Monitor: compare each emitted bit away from the active edge
    always @(negedge clk) begin
        if (rst_n) begin
            if (emit_q) begin
                logic e;
                if (exp_q.size() == 0) begin
                    check(1'b0, "R3 extra bit", 1, 0);
                end else begin
                    e = exp_q.pop_front();
                    check(tx_bit_o == e, (emitted < 64) ? "R1/R5 preamble bit" :
                          (emitted < 104) ? "R2/R5 sync bit" : "R3/R5 payload bit",
                          tx_bit_o, e);
                end
                emitted++;
            end
            if (underrun_o) under_cnt++;
            if (done_o) begin done_cnt++; done_at = emitted; end
        end
    end

    task automatic cycles(input int n);
        repeat (n) @(posedge clk);
        #2;
    endtask

    task automatic begin_burst(input bit zero_payload);
        feed_clr = 1'b1;
        cycles(1);
        feed_clr = 1'b0;
        emitted = 0; under_cnt = 0; done_cnt = 0; done_at = -1;
        push_burst(zero_payload);
        start_i = 1'b1;
        cycles(1);
        start_i = 1'b0;
    endtask

    task automatic wait_done();
        while (!done_o) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic end_checks(input int exp_acc, input int exp_under);
        check(done_at == 216, "R6 done with bit 216", done_at, 216);
        check(done_cnt == 1, "R6 single done pulse", done_cnt, 1);
        check(busy_o == 0 && tx_bit_o == 0 && byte_ready_o == 0,
              "R7 idle outputs", {busy_o, tx_bit_o, byte_ready_o}, 0);
        check(feed_idx == exp_acc, "R10 bytes accepted", feed_idx, exp_acc);
        check(under_cnt == exp_under, "R9 underrun pulses", under_cnt, exp_under);
        check(exp_q.size() == 0, "R3 burst length", exp_q.size(), 0);
    endtask

    initial begin
        #3_000_000;
        fails++;
        $display("FAIL watchdog actual=1 expected=0");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        for (int i = 0; i < 14; i++) pay[i] = 8'(i * 37 + 5);
        cycles(3);
        @(negedge clk);
        check({busy_o, done_o, tx_bit_o, byte_ready_o, underrun_o} == 0,
              "R11 reset state", {busy_o, done_o, tx_bit_o, byte_ready_o, underrun_o}, 0);
        rst_n = 1'b1;
        cycles(2);
        @(negedge clk);
        check(tx_bit_o == 0 && byte_ready_o == 0, "R7 idle before start",
              {tx_bit_o, byte_ready_o}, 0);
        cycles(1);

        // Burst A: every cycle paced, payload ready early (R1-R5, R10)
        feed_en = 1'b1;
        pace = 1;
        begin_burst(1'b0);
        wait_done();
        end_checks(14, 0);

        // Burst B: slow pacing, different payload, start while busy (R4, R8)
        for (int i = 0; i < 14; i++) pay[i] = 8'(8'hF0 ^ (i * 19));
        pace = 2;
        begin_burst(1'b0);
        cycles(150);
        start_i = 1'b1;
        cycles(1);
        start_i = 1'b0;
        @(negedge clk);
        check(busy_o == 1, "R8 start ignored while busy", busy_o, 1);
        wait_done();
        end_checks(14, 0);

        // Burst C: no payload supplied, every slot underruns (R9)
        feed_en = 1'b0;
        pace = 1;
        begin_burst(1'b1);
        wait_done();
        end_checks(0, 14);

        // Burst D: reset in the middle of a burst (R11)
        feed_en = 1'b1;
        begin_burst(1'b0);
        cycles(40);
        pace = 0;
        cycles(2);
        rst_n = 1'b0;
        cycles(2);
        @(negedge clk);
        check({busy_o, done_o, tx_bit_o, byte_ready_o} == 0, "R11 mid-burst reset",
              {busy_o, done_o, tx_bit_o, byte_ready_o}, 0);
        exp_q.delete();
        rst_n = 1'b1;
        cycles(2);

        // Burst E: full burst after reset, encoder memory cleared (R5, R11)
        pace = 1;
        begin_burst(1'b0);
        wait_done();
        end_checks(14, 0);

        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

endmodule